// File: doc/BRIEF.md
# MAC Pause Flow Controller

This block sits between the receive side and the transmit side of an Ethernet MAC and carries out the pause part of flow control. The receive path has already parsed the frame and checked its FCS. It then presents one strobe for a good MAC control frame, together with the frame's opcode and its 16-bit pause time. The time is given in quanta, where one quantum is 512 bit times. When the opcode selects PAUSE, the block loads a down-counter with that time. While the counter is nonzero, the block withdraws its permission for the transmit MAC to begin a new frame.

The permission gates only the start of frames. A frame that is already on the wire keeps going, and the transmitter reports it through a busy input. While busy is high the countdown is frozen. It starts, or resumes, once the transmitter goes idle. If the transmitter is idle when the frame arrives, the countdown starts at once. The quantum tick comes from outside, so the same block serves any link speed. A later pause frame overwrites whatever time is left, and that includes a value of zero, which lifts the pause at once.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A cycle with `ctl_valid` high and `ctl_opcode` equal to 16'h0001 (PAUSE) loads `pause_count` with `ctl_quanta`, visible in the next cycle.
- R2: `tx_allow` is high exactly when `pause_count` is zero, and low whenever it is nonzero.
- R3: A PAUSE frame that arrives while `pause_count` is nonzero replaces the remaining count with the new value, whether that value is larger or smaller.
- R4: While `tx_busy` is low and `pause_count` is nonzero, each cycle with `quanta_tick` high lowers the count by exactly one. Cycles without a tick leave it unchanged.
- R5: While `tx_busy` is high, `pause_count` does not decrement, even on ticks. The countdown resumes on the first tick after `tx_busy` falls.
- R6: A control frame with any opcode other than 16'h0001 leaves `pause_count` and `tx_allow` unchanged.
- R7: A PAUSE frame with a quanta value of zero sets `pause_count` to zero, so `tx_allow` is high in the following cycle.
- R8: When a PAUSE load and a tick occur in the same cycle, the load wins and the count equals the new quanta value with no decrement.
- R9: A tick while `pause_count` is zero leaves it at zero and does not wrap.
- R10: After reset, `pause_count` is zero and `tx_allow` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_valid | input | 1 | One-cycle strobe for a received control frame with good FCS |
| ctl_opcode | input | 16 | Opcode of that control frame |
| ctl_quanta | input | 16 | Pause time from the frame, in quanta |
| tx_busy | input | 1 | High while the transmit MAC is sending a frame |
| quanta_tick | input | 1 | One-cycle pulse every 512 bit times at the current link speed |
| tx_allow | output | 1 | High when the transmit MAC may begin a new frame |
| pause_count | output | 16 | Remaining pause time in quanta |

## Verification
The bench targets four cases that are easy to get wrong: a load and a tick in the same cycle, ticks that arrive while the transmitter is busy, a reload in the middle of a pause, and ticks at a count of zero. A design that gave the tick priority would come up one short after the load. A design that ignored busy would shorten the pause while a frame was still being sent. One that merged or ignored a reload would release the transmitter at the wrong time, and one without a zero guard would wrap to 16'hFFFF and stall transmission for a long time. Foreign opcodes and zero-quanta frames are checked at `tx_allow` and `pause_count` in the cycle after they arrive.

// File: rtl/pfc_pkg.sv
// Shared constants for the pause flow controller.
// Assumes the PAUSE opcode of a MAC control frame is 16'h0001.
package pfc_pkg;
    localparam int unsigned PFC_CNT_W = 16;
    localparam int unsigned PFC_OPC_W = 16;
    localparam logic [15:0] PFC_PAUSE_OPCODE = 16'h0001;
endpackage

// File: rtl/pfc_opcode_decode.sv
// Turns a control-frame strobe into a load request when the opcode is PAUSE.
// Assumes the strobe is only raised for frames whose FCS has already been checked.
module pfc_opcode_decode #(
    parameter int unsigned OPC_W = 16,
    parameter logic [OPC_W-1:0] PAUSE_OPC = OPC_W'(1)
) (
    input  logic             frame_valid,
    input  logic [OPC_W-1:0] frame_opcode,
    output logic             pause_load
);
    // Match the opcode against the PAUSE value.
    always_comb begin
        pause_load = frame_valid && (frame_opcode == PAUSE_OPC);
    end
endmodule

// File: rtl/pfc_quanta_counter.sv
// Holds the remaining pause time. A load has priority over everything else.
// A decrement happens on a tick only while the transmitter is idle and the count is nonzero.
// Assumes the tick is one cycle wide per quantum.
module pfc_quanta_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic             tick,
    input  logic             hold,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic count_nz;

    // Flag a nonzero count, used to guard the decrement against wrapping.
    always_comb begin
        count_nz = (count != ZERO);
    end

    // Register the count: load first, then the gated decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= ZERO;
        end else if (load) begin
            count <= load_value;
        end else if (tick && !hold && count_nz) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/pfc_tx_gate.sv
// Derives the start-of-frame permission from the pause count.
// Assumes the transmit MAC samples the permission only when it is about to start a frame,
// so a frame already in flight is never cut short.
module pfc_tx_gate #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    output logic             allow
);
    // XON when no pause time remains, XOFF otherwise.
    always_comb begin
        allow = (count == '0);
    end
endmodule

// File: rtl/pause_flow_ctrl.sv
// Top of the pause flow controller. It loads a quanta counter from received PAUSE frames,
// freezes the countdown while a frame is being transmitted, and gates the start of new frames.
// Assumes a synchronous active-low reset and an external tick of 512 bit times.
module pause_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int unsigned CNT_W = PFC_CNT_W,
    parameter int unsigned OPC_W = PFC_OPC_W,
    parameter logic [OPC_W-1:0] PAUSE_OPC = OPC_W'(PFC_PAUSE_OPCODE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_valid,
    input  logic [OPC_W-1:0] ctl_opcode,
    input  logic [CNT_W-1:0] ctl_quanta,
    input  logic             tx_busy,
    input  logic             quanta_tick,
    output logic             tx_allow,
    output logic [CNT_W-1:0] pause_count
);
    logic pause_load;

    pfc_opcode_decode #(.OPC_W(OPC_W), .PAUSE_OPC(PAUSE_OPC)) u_dec (
        .frame_valid  (ctl_valid),
        .frame_opcode (ctl_opcode),
        .pause_load   (pause_load)
    );

    pfc_quanta_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pause_load),
        .load_value (ctl_quanta),
        .tick       (quanta_tick),
        .hold       (tx_busy),
        .count      (pause_count)
    );

    pfc_tx_gate #(.CNT_W(CNT_W)) u_gate (
        .count (pause_count),
        .allow (tx_allow)
    );
endmodule

// File: rtl/pause_flow_ctrl_chk.sv
// Checker for the pause flow controller. It observes only the top-level ports.
module pause_flow_ctrl_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OPC_W = 16,
    parameter logic [OPC_W-1:0] PAUSE_OPC = OPC_W'(1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_valid,
    input logic [OPC_W-1:0] ctl_opcode,
    input logic [CNT_W-1:0] ctl_quanta,
    input logic             tx_busy,
    input logic             quanta_tick,
    input logic             tx_allow,
    input logic [CNT_W-1:0] pause_count
);
    logic is_pause;
    assign is_pause = ctl_valid && (ctl_opcode == PAUSE_OPC);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        is_pause |=> pause_count == $past(ctl_quanta)); // R1

    AST_ALLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_allow |-> pause_count == '0); // R2

    AST_BLOCK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pause_count != '0 |-> !tx_allow); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pause && quanta_tick && !tx_busy && pause_count != '0)
        |=> pause_count == $past(pause_count) - CNT_W'(1)); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pause && tx_busy) |=> $stable(pause_count)); // R5

    AST_FOREIGN_OPC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !is_pause && !quanta_tick) |=> $stable(pause_count)); // R6

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_pause && pause_count == '0) |=> pause_count == '0); // R9
endmodule

bind pause_flow_ctrl pause_flow_ctrl_chk #(
    .CNT_W(CNT_W), .OPC_W(OPC_W), .PAUSE_OPC(PAUSE_OPC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_valid   (ctl_valid),
    .ctl_opcode  (ctl_opcode),
    .ctl_quanta  (ctl_quanta),
    .tx_busy     (tx_busy),
    .quanta_tick (quanta_tick),
    .tx_allow    (tx_allow),
    .pause_count (pause_count)
);

// File: tb/sim_pause_flow_ctrl.sv
// Directed bench for the pause flow controller. Each task drives one scenario and checks it.
module sim_pause_flow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [15:0] ctl_opcode = 16'h0;
    logic [15:0] ctl_quanta = 16'h0;
    logic        tx_busy = 1'b0;
    logic        quanta_tick = 1'b0;
    logic        tx_allow;
    logic [15:0] pause_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_opcode(ctl_opcode),
        .ctl_quanta(ctl_quanta), .tx_busy(tx_busy), .quanta_tick(quanta_tick),
        .tx_allow(tx_allow), .pause_count(pause_count)
    );

    // Watchdog: an overlong run counts as a failure and still reaches the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Drive one cycle of inputs just after an edge, then return 1 time unit after the next edge.
    task automatic step(input bit v, input logic [15:0] op, input logic [15:0] q,
                        input bit busy, input bit tick);
        ctl_valid   = v;
        ctl_opcode  = op;
        ctl_quanta  = q;
        tx_busy     = busy;
        quanta_tick = tick;
        @(posedge clk);
        #1;
        ctl_valid   = 1'b0;
        quanta_tick = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] cnt_exp);
        logic allow_exp;
        allow_exp = (cnt_exp == 16'h0);
        n_checks = n_checks + 1;
        if (pause_count !== cnt_exp || tx_allow !== allow_exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: count=%0d allow=%0b expected count=%0d allow=%0b",
                     req, pause_count, tx_allow, cnt_exp, allow_exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(0, 16'h0, 16'h0, 0, 0);
        step(0, 16'h0, 16'h0, 0, 0);
        rst_n = 1'b1;
        check("R10 reset state", 16'd0);
    endtask

    task automatic t_load_and_count;
        step(1, 16'h0001, 16'd5, 0, 0);
        check("R1 load", 16'd5);
        step(0, 16'h0, 16'h0, 0, 0);
        check("R4 no tick holds", 16'd5);
        for (int i = 4; i >= 0; i--) begin
            step(0, 16'h0, 16'h0, 0, 1);
            check("R4 decrement", 16'(i));
        end
        check("R2 xon at zero", 16'd0);
    endtask

    task automatic t_busy_hold;
        step(1, 16'h0001, 16'd4, 1, 0);
        check("R1 load while busy", 16'd4);
        for (int i = 0; i < 3; i++) begin
            step(0, 16'h0, 16'h0, 1, 1);
            check("R5 busy freezes count", 16'd4);
        end
        step(0, 16'h0, 16'h0, 0, 0);
        check("R5 idle without tick", 16'd4);
        step(0, 16'h0, 16'h0, 0, 1);
        check("R5 resume after busy", 16'd3);
        step(0, 16'h0, 16'h0, 0, 1);
        step(0, 16'h0, 16'h0, 0, 1);
        step(0, 16'h0, 16'h0, 0, 1);
        check("R2 release", 16'd0);
    endtask

    task automatic t_reload;
        step(1, 16'h0001, 16'd10, 0, 0);
        step(0, 16'h0, 16'h0, 0, 1);
        check("R4 first tick", 16'd9);
        step(1, 16'h0001, 16'd3, 0, 0);
        check("R3 reload smaller", 16'd3);
        step(1, 16'h0001, 16'd200, 0, 0);
        check("R3 reload larger", 16'd200);
        step(1, 16'h0001, 16'hFFFF, 0, 0);
        check("R3 reload max", 16'hFFFF);
    endtask

    task automatic t_zero_quanta;
        step(1, 16'h0001, 16'd0, 0, 0);
        check("R7 zero quanta releases", 16'd0);
    endtask

    task automatic t_foreign_opcode;
        step(1, 16'h0002, 16'd7, 0, 0);
        check("R6 foreign opcode while idle", 16'd0);
        step(1, 16'h0001, 16'd6, 0, 0);
        step(1, 16'h0000, 16'd50, 0, 0);
        check("R6 opcode zero during pause", 16'd6);
        step(1, 16'h0101, 16'd1, 0, 0);
        check("R6 opcode 0x0101 during pause", 16'd6);
    endtask

    task automatic t_priority;
        step(1, 16'h0001, 16'd9, 0, 1);
        check("R8 load beats tick", 16'd9);
        step(1, 16'h0001, 16'd1, 0, 0);
        step(0, 16'h0, 16'h0, 0, 1);
        check("R4 one to zero", 16'd0);
    endtask

    task automatic t_no_wrap;
        step(0, 16'h0, 16'h0, 0, 1);
        check("R9 tick at zero", 16'd0);
        step(0, 16'h0, 16'h0, 0, 1);
        check("R9 second tick at zero", 16'd0);
    endtask

    initial begin
        t_reset();
        t_load_and_count();
        t_busy_hold();
        t_reload();
        t_zero_quanta();
        t_foreign_opcode();
        t_priority();
        t_no_wrap();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule